// File: doc/BRIEF.md
# Serial Flash Power-Down and Signature Responder

This block is the slave-side logic of a serial flash device that answers two instructions. One instruction releases the device from deep power-down and reads the signature. The other instruction enters deep power-down. The SPI pins (`cs_n`, `sck`, `mosi`) are oversampled by the system clock through a configurable synchronizer. The responder works in SPI mode 0: the slave samples `mosi` on rising `sck` edges and changes `miso` on falling edges. The output pin is modelled as a data bit `miso` plus a drive enable `miso_oe`, and the pad buffer sits outside the block.

The block tracks the device's power state:
- **Stand-by** accepts the release/signature opcode and the power-down opcode.
- **Deep power-down** ignores everything except the release/signature opcode.
- **Wake-up** is entered when a release issued from deep power-down ends with the signature read at least once. It lasts a programmable number of system clocks, then the device returns to stand-by. Select activity during this window is ignored.

A `busy` input marks an erase, program or status-write cycle in progress. While `busy` is high, neither opcode is decoded.

Top module: `spi_pd_responder`

## Requirements
- R1: After synchronous reset, `power_mode` is 0 (stand-by), `miso_oe` is 0 and `miso` is 0. The `power_mode` encoding is 0 = stand-by, 1 = deep power-down, 2 = wake-up.
- R2: `miso_oe` is 1 only while signature bits are being driven. When `miso_oe` is 0, `miso` is 0. Deselect (`cs_n` high) clears `miso_oe`.
- R3: After opcode ABh (bits taken MSB first on rising `sck`) and DUMMY_BYTES further bytes (32 rising edges by default), each falling `sck` edge drives the next bit of signature 13h, MSB first. The first bit appears on the falling edge that follows the last dummy rising edge.
- R4: While `cs_n` stays low and clocking continues, the signature repeats without a gap: bit 7 follows bit 0.
- R5: Opcode ABh issued in stand-by returns the signature and leaves `power_mode` at stand-by.
- R6: Opcode B9h in stand-by enters deep power-down when `cs_n` rises after exactly 8 rising `sck` edges. One or more extra rising edges before the deselect cancel the entry.
- R7: In deep power-down, any opcode other than ABh produces no output and leaves the mode unchanged.
- R8: In deep power-down, an ABh frame moves the mode to wake-up on deselect only if all 8 signature bits were sampled (8 rising edges after the first driven bit). The mode then stays in wake-up for exactly WAKE_CYCLES clocks before returning to stand-by. A frame deselected earlier leaves the device in deep power-down.
- R9: When `busy` is high at the 8th rising edge of a frame, the opcode is not decoded. There is no signature output, and no mode change follows from that frame.
- R10: A frame whose select falls while the mode is wake-up is ignored entirely. It produces no output even if it continues past the end of the wake-up window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low (asynchronous to `clk`) |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data in |
| busy | input | 1 | Erase, program or status write in progress |
| miso | output | 1 | Serial data out bit |
| miso_oe | output | 1 | Drive enable for the serial data out pad |
| power_mode | output | 2 | 0 stand-by, 1 deep power-down, 2 wake-up |

## Verification
The bench builds the block with WAKE_CYCLES = 40, SYNC_STAGES = 2 and DUMMY_BYTES = 3, and drives `sck` with a half period of 6 system clocks.

The short wake-up window brings two cases within reach of a few frames:
- a select that falls inside the window;
- a frame that runs well past the window's end.

It also lets the bench count the window length cycle by cycle. With the default depth of 3000, neither case would fit a compact run.

The reference model applies the same synchronizer delay to the pin history, so every clock compares mode, enable and data.

// File: rtl/spi_pd_pkg.sv
package spi_pd_pkg;

    typedef enum logic [1:0] {
        PM_STANDBY = 2'd0,
        PM_DEEP    = 2'd1,
        PM_WAKE    = 2'd2
    } pwr_mode_t;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_RELEASE = 2'd1,
        CMD_SLEEP   = 2'd2
    } cmd_t;

    localparam logic [7:0] OPC_RELEASE = 8'hAB;
    localparam logic [7:0] OPC_SLEEP   = 8'hB9;
    localparam logic [7:0] SIG_VALUE   = 8'h13;
    localparam int         CMD_BITS    = 8;
    localparam int         SIG_BITS    = 8;

    // Synchronized pin events, one system clock wide.
    typedef struct packed {
        logic select;
        logic deselect;
        logic sck_rise;
        logic sck_fall;
        logic data;
    } pin_ev_t;

    // Summary of a frame handed to the power tracker on deselect.
    typedef struct packed {
        logic done;
        logic release_ok;
        logic sleep_ok;
    } frame_end_t;

    function automatic cmd_t decode_cmd(input logic [7:0] opc,
                                        input pwr_mode_t  mode,
                                        input logic       busy);
        cmd_t c;
        c = CMD_NONE;
        if (!busy && mode != PM_WAKE) begin
            if (opc == OPC_RELEASE)
                c = CMD_RELEASE;
            else if (opc == OPC_SLEEP && mode == PM_STANDBY)
                c = CMD_SLEEP;
        end
        return c;
    endfunction

endpackage

// File: rtl/spi_pd_sync.sv
module spi_pd_sync
    import spi_pd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sck,
    input  logic    mosi,
    output pin_ev_t ev
);
    // Bit order inside each 3-bit slot: {cs_n, sck, mosi}
    localparam logic [2:0] IDLE = 3'b100;
    localparam int         W    = 3 * STAGES;

    logic [W-1:0] chain_q;
    logic [2:0]   last;
    logic [2:0]   prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= IDLE;
                else     chain_q <= {cs_n, sck, mosi};
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{IDLE}};
                else     chain_q <= {chain_q[W-4:0], cs_n, sck, mosi};
            end
        end
    endgenerate

    assign last = chain_q[W-1 -: 3];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE;
        else     prev_q <= last;
    end

    always_comb begin
        ev.select   =  prev_q[2] & ~last[2];
        ev.deselect = ~prev_q[2] &  last[2];
        ev.sck_rise = ~prev_q[1] &  last[1];
        ev.sck_fall =  prev_q[1] & ~last[1];
        ev.data     =  last[0];
    end

endmodule

// File: rtl/spi_pd_frame.sv
module spi_pd_frame
    import spi_pd_pkg::*;
#(
    parameter int DUMMY_BYTES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  pin_ev_t    ev,
    input  logic       busy,
    input  pwr_mode_t  mode,
    output logic       miso,
    output logic       miso_oe,
    output frame_end_t fend
);
    localparam int DATA_START = CMD_BITS * (1 + DUMMY_BYTES);
    localparam int BW         = $clog2(DATA_START + 1);
    localparam int IW         = $clog2(SIG_BITS);

    logic                active_q;
    logic [BW-1:0]       bitcnt_q;
    logic [CMD_BITS-1:0] rx_q;
    cmd_t                cmd_q;
    logic [IW-1:0]       idx_q;
    logic                oe_q;
    logic                bit_q;
    logic                sig_read_q;

    logic                in_data;
    logic [CMD_BITS-1:0] opc_next;

    assign in_data  = (cmd_q == CMD_RELEASE) && (bitcnt_q == BW'(DATA_START));
    assign opc_next = {rx_q[CMD_BITS-2:0], ev.data};

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            bitcnt_q   <= '0;
            rx_q       <= '0;
            cmd_q      <= CMD_NONE;
            idx_q      <= '0;
            oe_q       <= 1'b0;
            bit_q      <= 1'b0;
            sig_read_q <= 1'b0;
        end else if (ev.deselect) begin
            active_q <= 1'b0;
            oe_q     <= 1'b0;
        end else if (ev.select) begin
            active_q   <= (mode != PM_WAKE);
            bitcnt_q   <= '0;
            cmd_q      <= CMD_NONE;
            idx_q      <= '0;
            oe_q       <= 1'b0;
            sig_read_q <= 1'b0;
        end else if (active_q) begin
            if (ev.sck_rise) begin
                if (bitcnt_q < BW'(CMD_BITS)) begin
                    rx_q     <= opc_next;
                    bitcnt_q <= bitcnt_q + 1'b1;
                    if (bitcnt_q == BW'(CMD_BITS - 1))
                        cmd_q <= decode_cmd(opc_next, mode, busy);
                end else if (bitcnt_q < BW'(DATA_START)) begin
                    bitcnt_q <= bitcnt_q + 1'b1;
                end else if (in_data && oe_q && idx_q == '0) begin
                    sig_read_q <= 1'b1;
                end
            end
            if (ev.sck_fall && in_data) begin
                oe_q  <= 1'b1;
                bit_q <= SIG_VALUE[IW'(SIG_BITS - 1) - idx_q];
                idx_q <= (idx_q == IW'(SIG_BITS - 1)) ? '0 : idx_q + 1'b1;
            end
        end
    end

    assign miso_oe = oe_q;
    assign miso    = oe_q & bit_q;

    always_comb begin
        fend.done       = ev.deselect & active_q;
        fend.release_ok = (cmd_q == CMD_RELEASE) & sig_read_q;
        fend.sleep_ok   = (cmd_q == CMD_SLEEP) & (bitcnt_q == BW'(CMD_BITS));
    end

    // R2: the pad is driven only in the data phase of a release frame
    p_oe_in_data_r2: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> (active_q && in_data));

    // R2: deselect always releases the pad
    p_oe_off_after_desel_r2: assert property (@(posedge clk) disable iff (rst)
        ev.deselect |=> !oe_q);

    // R3: the first driven bit is the signature MSB
    p_first_bit_msb_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_q) |-> (bit_q == SIG_VALUE[SIG_BITS-1]));

    // R9: busy at the opcode's last edge blocks decoding
    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (active_q && !ev.deselect && !ev.select && ev.sck_rise &&
         bitcnt_q == BW'(CMD_BITS - 1) && busy) |=> (cmd_q == CMD_NONE));

    // R10: no frame is live during the wake-up window
    p_idle_in_wake_r10: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_WAKE) |-> !active_q);

endmodule

// File: rtl/spi_pd_power.sv
module spi_pd_power
    import spi_pd_pkg::*;
#(
    parameter int WAKE_CYCLES = 3000
) (
    input  logic       clk,
    input  logic       rst,
    input  frame_end_t fend,
    output pwr_mode_t  mode
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);

    pwr_mode_t     mode_q;
    logic [CW-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_STANDBY;
            wait_q <= '0;
        end else begin
            unique case (mode_q)
                PM_STANDBY: begin
                    if (fend.done && fend.sleep_ok)
                        mode_q <= PM_DEEP;
                end
                PM_DEEP: begin
                    if (fend.done && fend.release_ok) begin
                        mode_q <= PM_WAKE;
                        wait_q <= CW'(WAKE_CYCLES - 1);
                    end
                end
                PM_WAKE: begin
                    if (wait_q == '0) mode_q <= PM_STANDBY;
                    else              wait_q <= wait_q - 1'b1;
                end
                default: mode_q <= PM_STANDBY;
            endcase
        end
    end

    assign mode = mode_q;

    // R8: the wake-up window is only reached from deep power-down
    p_wake_from_deep_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_WAKE && $past(mode_q) != PM_WAKE) |-> ($past(mode_q) == PM_DEEP));

    // R8: leaving the wake-up window always lands in stand-by
    p_wake_to_standby_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) == PM_WAKE && mode_q != PM_WAKE) |-> (mode_q == PM_STANDBY));

    // R7: deep power-down holds unless a frame ends
    p_deep_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_DEEP && !fend.done) |=> (mode_q == PM_DEEP));

endmodule

// File: rtl/spi_pd_responder.sv
module spi_pd_responder
    import spi_pd_pkg::*;
#(
    parameter int WAKE_CYCLES = 3000,
    parameter int SYNC_STAGES = 2,
    parameter int DUMMY_BYTES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic       busy,
    output logic       miso,
    output logic       miso_oe,
    output logic [1:0] power_mode
);
    pin_ev_t    ev;
    frame_end_t fend;
    pwr_mode_t  mode;

    spi_pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sck  (sck),
        .mosi (mosi),
        .ev   (ev)
    );

    spi_pd_frame #(.DUMMY_BYTES(DUMMY_BYTES)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .busy    (busy),
        .mode    (mode),
        .miso    (miso),
        .miso_oe (miso_oe),
        .fend    (fend)
    );

    spi_pd_power #(.WAKE_CYCLES(WAKE_CYCLES)) u_power (
        .clk  (clk),
        .rst  (rst),
        .fend (fend),
        .mode (mode)
    );

    assign power_mode = mode;

    // R1: only the three defined mode codes appear
    p_mode_legal_r1: assert property (@(posedge clk) disable iff (rst)
        power_mode != 2'd3);

endmodule

// File: tb/spi_pd_responder_tb.sv
module spi_pd_responder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WAKE       = 40;
    localparam int SYNC       = 2;
    localparam int HALF       = 6;
    localparam int MAX_CYCLES = 100000;
    localparam logic [7:0] SIG = 8'h13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0;
    logic miso, miso_oe;
    logic [1:0] power_mode;

    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit oe_seen = 0;
    bit timeout = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_pd_responder #(.WAKE_CYCLES(WAKE), .SYNC_STAGES(SYNC), .DUMMY_BYTES(3)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .busy(busy),
        .miso(miso), .miso_oe(miso_oe), .power_mode(power_mode)
    );

    // ---------------- behavioural reference model ----------------
    logic [2:0] hist[$];
    int  m_mode, m_left, m_nrise, m_nfall;
    bit  m_frame, m_sig_ok, m_oe, m_bit;
    int  m_kind;            // 0 none, 1 release, 2 sleep
    logic [7:0] m_opc;

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            for (int i = 0; i <= SYNC; i++) hist.push_back(3'b100);
            m_mode = 0; m_left = 0; m_frame = 0; m_oe = 0; m_bit = 0;
            m_nrise = 0; m_nfall = 0; m_kind = 0; m_sig_ok = 0; m_opc = 0;
        end else begin
            logic [2:0] cur, old;
            int mode_before;
            cur = hist[1];
            old = hist[0];
            void'(hist.pop_front());
            hist.push_back({cs_n, sck, mosi});
            mode_before = m_mode;
            if (!old[2] && cur[2]) begin
                if (m_frame && mode_before == 1 && m_kind == 1 && m_sig_ok) begin
                    m_mode = 2; m_left = WAKE;
                end
                if (m_frame && mode_before == 0 && m_kind == 2 && m_nrise == 8)
                    m_mode = 1;
                m_frame = 0; m_oe = 0;
            end else if (old[2] && !cur[2]) begin
                if (mode_before != 2) begin
                    m_frame = 1; m_nrise = 0; m_nfall = 0; m_kind = 0;
                    m_sig_ok = 0; m_opc = 0; m_oe = 0;
                end
            end else if (m_frame) begin
                if (!old[1] && cur[1]) begin
                    if (m_nrise < 8) begin
                        m_opc = {m_opc[6:0], cur[0]};
                        m_nrise++;
                        if (m_nrise == 8) begin
                            if (busy) m_kind = 0;
                            else if (m_opc == 8'hAB) m_kind = 1;
                            else if (m_opc == 8'hB9 && mode_before == 0) m_kind = 2;
                            else m_kind = 0;
                        end
                    end else if (m_nrise < 32) begin
                        m_nrise++;
                    end else if (m_kind == 1 && m_nfall >= 8) begin
                        m_sig_ok = 1;
                    end
                end
                if (old[1] && !cur[1] && m_kind == 1 && m_nrise >= 32) begin
                    m_oe  = 1;
                    m_bit = SIG[7 - (m_nfall % 8)];
                    m_nfall++;
                end
            end
            if (mode_before == 2) begin
                m_left--;
                if (m_left == 0) m_mode = 0;
            end
        end
    end

    // ---------------- per-clock comparison ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check(power_mode == 2'(m_mode), cur_req, "power_mode", power_mode, m_mode);
            check(miso_oe == m_oe, "R2", "miso_oe", miso_oe, m_oe);
            check(miso == (m_oe & m_bit), "R3", "miso", miso, m_oe & m_bit);
            if (miso_oe) oe_seen = 1;
        end
    end

    // ---------------- SPI driver tasks ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic desel();
        cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            tick(HALF);
            rx[i] = miso;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic head(input logic [7:0] opc);
        logic [7:0] junk;
        xfer(opc, junk);
        for (int i = 0; i < 3; i++) xfer(8'h00, junk);
    endtask

    task automatic partial(input int nbits);
        for (int i = 0; i < nbits; i++) begin
            tick(HALF);
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic run_tests();
        logic [7:0] rb;
        int n;

        // R1: reset state
        cur_req = "R1";
        tick(2);
        check(power_mode == 2'd0, "R1", "mode after reset", power_mode, 0);
        check(miso_oe == 1'b0, "R1", "oe after reset", miso_oe, 0);
        check(miso == 1'b0, "R1", "miso after reset", miso, 0);

        // R3 R4 R5: signature in stand-by, read twice
        cur_req = "R5";
        sel(); head(8'hAB);
        xfer(8'h00, rb); check(rb == SIG, "R3", "first signature", rb, SIG);
        xfer(8'h00, rb); check(rb == SIG, "R4", "repeated signature", rb, SIG);
        desel();
        check(miso_oe == 1'b0, "R2", "oe after deselect", miso_oe, 0);
        check(power_mode == 2'd0, "R5", "mode after standby release", power_mode, 0);

        // R6: extra clock cancels power-down
        cur_req = "R6";
        sel(); xfer(8'hB9, rb); partial(1); desel();
        check(power_mode == 2'd0, "R6", "B9 plus one bit", power_mode, 0);

        // R9: busy blocks both opcodes
        cur_req = "R9";
        busy = 1'b1;
        sel(); xfer(8'hB9, rb); desel();
        check(power_mode == 2'd0, "R9", "B9 while busy", power_mode, 0);
        oe_seen = 0;
        sel(); head(8'hAB); xfer(8'h00, rb); desel();
        check(oe_seen == 0, "R9", "AB while busy drove pad", oe_seen, 0);
        busy = 1'b0;

        // R6: exact B9 enters deep power-down
        cur_req = "R6";
        sel(); xfer(8'hB9, rb); desel();
        check(power_mode == 2'd1, "R6", "B9 exact", power_mode, 1);

        // R7: other opcodes ignored in deep
        cur_req = "R7";
        oe_seen = 0;
        sel(); head(8'h03); xfer(8'h00, rb); desel();
        check(oe_seen == 0, "R7", "other opcode drove pad", oe_seen, 0);
        check(power_mode == 2'd1, "R7", "mode after other opcode", power_mode, 1);

        // R9: busy AB in deep does nothing
        cur_req = "R9";
        busy = 1'b1; oe_seen = 0;
        sel(); head(8'hAB); xfer(8'h00, rb); desel();
        busy = 1'b0;
        check(oe_seen == 0 && power_mode == 2'd1, "R9", "busy release in deep",
              power_mode, 1);

        // R8: early deselect keeps deep
        cur_req = "R8";
        sel(); head(8'hAB); partial(5); desel();
        check(power_mode == 2'd1, "R8", "release with 5 bits", power_mode, 1);

        // R8: full release, count the wake window
        sel(); head(8'hAB);
        xfer(8'h00, rb); check(rb == SIG, "R8", "signature in deep", rb, SIG);
        cs_n = 1'b1;
        n = 0;
        for (int i = 0; i < 4 * WAKE; i++) begin
            tick(1);
            if (power_mode == 2'd2) n++;
            else if (n > 0) break;
        end
        check(n == WAKE, "R8", "wake window length", n, WAKE);
        check(power_mode == 2'd0, "R8", "mode after wake", power_mode, 0);

        // R10: select during wake is ignored
        cur_req = "R10";
        sel(); xfer(8'hB9, rb); desel();
        sel(); head(8'hAB); xfer(8'h00, rb);
        cs_n = 1'b1;
        tick(HALF);
        check(power_mode == 2'd2, "R10", "wake entered", power_mode, 2);
        oe_seen = 0;
        sel(); head(8'hAB); xfer(8'h00, rb); desel();
        check(oe_seen == 0, "R10", "frame in wake drove pad", oe_seen, 0);
        check(power_mode == 2'd0, "R10", "mode after ignored frame", power_mode, 0);

        // R5: normal service afterwards
        cur_req = "R5";
        sel(); head(8'hAB); xfer(8'h00, rb); desel();
        check(rb == SIG, "R5", "signature after wake", rb, SIG);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        fork
            run_tests();
            begin
                repeat (MAX_CYCLES) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule